// File: doc/BRIEF.md
# BF16 Immediate Floating-Point Register Loader

This unit computes the next value of one 64-bit double-precision register from a 16-bit bfloat16 immediate. It has two operations. The load operation places the immediate in the upper half of a single-precision word, with the lower half cleared, and then widens that word to double precision. The patch operation first narrows the current register value to single precision. It then overwrites the lower 16 bits of that single-precision word with the immediate and widens the word back to double precision.

Together the two operations give two-step construction of any single-precision constant: a load writes the top half and a patch writes the bottom half. The caller presents the operation, the immediate and the current register value with a valid strobe. The new register value appears one cycle later, qualified by a one-cycle valid flag. The caller writes that value back to the register.

Top module: `bf16_fpreg_loader`

## Requirements
- R1: When `in_op` is 0 (load), the result is the double-precision value of the single-precision word {in_imm, 16'h0000}. Immediate 0x0000 gives 0x0000_0000_0000_0000 (+0.0) and 0x8000 gives 0x8000_0000_0000_0000 (-0.0).
- R2: Normal single-precision values widen exactly: the exponent is rebiased by +896 and the 23 fraction bits become the top of the 52-bit fraction. Loading 0x3F80 gives 0x3FF0_0000_0000_0000, 0xBFC0 gives 0xBFF8_0000_0000_0000, and 0x3FFF gives 0x3FFF_E000_0000_0000. Result bits 28..0 are always zero.
- R3: A single-precision exponent of 255 widens to 2047, and the fraction is kept. Loading 0x7F80 gives 0x7FF0_0000_0000_0000, 0xFF80 gives 0xFFF0_0000_0000_0000, and 0x7FC0 gives the quiet NaN 0x7FF8_0000_0000_0000.
- R4: A subnormal single-precision value is normalized exactly. Loading 0x0001 gives 0x37A0_0000_0000_0000 (2^-133) and 0x0040 gives 0x3800_0000_0000_0000 (2^-127).
- R5: When `in_op` is 1 (patch), the result is the widening of {narrow(in_reg)[31:16], in_imm}. A register of 0x3FF0_0000_0000_0000 patched with 0x8000 gives 0x3FF0_1000_0000_0000.
- R6: Narrowing truncates and never rounds: it keeps the sign and the top 23 fraction bits and drops the rest. A register of 0x3FF0_0000_1FFF_FFFF patched with 0x0000 gives 0x3FF0_0000_0000_0000.
- R7: Narrowing clamps values outside the single-precision range. A register exponent above 1150 (finite) becomes an infinity. An exponent of 896 or less, or zero, becomes a signed zero. A NaN keeps its top 23 fraction bits, and if those bits are all zero, fraction bit 22 is set.
- R8: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. `out_value` changes only after a valid input and otherwise holds its value.
- R9: While `rst_n` is low, `out_valid` is 0 and `out_value` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 1 | 0 = load, 1 = patch low half |
| in_imm | input | 16 | bfloat16 immediate |
| in_reg | input | 64 | Current double-precision register value |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_value | output | 64 | New register value |

## Verification
The clocked properties assume that `in_valid`, `in_op` and `in_imm` carry known values at every sampled edge after reset. They also assume that `in_valid` is low during reset, so that the first comparison against the previous cycle is meaningful. The bench drives every input on the falling clock edge and holds `in_valid` low throughout reset. It lowers the strobe between operations except in the back-to-back case, so each sampled edge sees a settled, fully defined input set.

// File: rtl/bfl_pkg.sv
package bfl_pkg;
   typedef enum logic {
      OP_LOAD  = 1'b0,
      OP_PATCH = 1'b1
   } bfl_op_e;
endpackage

// File: rtl/bfl_lead_one.sv
module bfl_lead_one #(
   parameter int W  = 23,
   localparam int PW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic [PW-1:0] pos,
   output logic          found
);
   if (W < 2) begin : g_bad_w
      $error("bfl_lead_one: W must be at least 2");
   end

   always_comb begin
      pos   = '0;
      found = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) begin
            pos   = PW'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/bfl_widen.sv
module bfl_widen #(
   parameter int SP_EXP_W = 8,
   parameter int SP_MAN_W = 23,
   parameter int DP_EXP_W = 11,
   parameter int DP_MAN_W = 52,
   parameter bit NORM_SUB = 1'b1,
   localparam int SP_W = 1 + SP_EXP_W + SP_MAN_W,
   localparam int DP_W = 1 + DP_EXP_W + DP_MAN_W
) (
   input  logic [SP_W-1:0] sp,
   output logic [DP_W-1:0] dp
);
   localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
   localparam int DP_BIAS   = (1 << (DP_EXP_W - 1)) - 1;
   localparam int BIAS_DIFF = DP_BIAS - SP_BIAS;
   localparam int PAD       = DP_MAN_W - SP_MAN_W;
   localparam int SUB_BASE  = BIAS_DIFF - SP_MAN_W + 1;
   localparam int PW        = $clog2(SP_MAN_W);

   if (DP_MAN_W <= SP_MAN_W || DP_EXP_W <= SP_EXP_W) begin : g_bad_fmt
      $error("bfl_widen: target format must be wider in both fields");
   end

   logic                s_sign;
   logic [SP_EXP_W-1:0] s_exp;
   logic [SP_MAN_W-1:0] s_man;
   logic [DP_EXP_W-1:0] sub_exp;
   logic [DP_MAN_W-1:0] sub_frac;

   assign s_sign = sp[SP_W-1];
   assign s_exp  = sp[SP_W-2:SP_MAN_W];
   assign s_man  = sp[SP_MAN_W-1:0];

   if (NORM_SUB) begin : g_norm
      logic [PW-1:0]       lead_pos;
      logic                lead_found;
      logic [PW-1:0]       shamt;
      logic [SP_MAN_W-1:0] norm;

      bfl_lead_one #(.W(SP_MAN_W)) u_lead (
         .vec  (s_man),
         .pos  (lead_pos),
         .found(lead_found)
      );

      assign shamt    = PW'(SP_MAN_W - 1) - lead_pos;
      assign norm     = s_man << shamt;
      assign sub_frac = lead_found ? {norm[SP_MAN_W-2:0], {(PAD + 1){1'b0}}} : '0;
      assign sub_exp  = lead_found ? (DP_EXP_W'(SUB_BASE) + DP_EXP_W'(lead_pos)) : '0;
   end else begin : g_flush
      assign sub_frac = '0;
      assign sub_exp  = '0;
   end

   always_comb begin
      if (&s_exp) begin
         dp = {s_sign, {DP_EXP_W{1'b1}}, s_man, {PAD{1'b0}}};
      end else if (s_exp == '0) begin
         dp = {s_sign, sub_exp, sub_frac};
      end else begin
         dp = {s_sign, DP_EXP_W'(s_exp) + DP_EXP_W'(BIAS_DIFF), s_man, {PAD{1'b0}}};
      end
   end
endmodule

// File: rtl/bfl_narrow.sv
module bfl_narrow #(
   parameter int SP_EXP_W = 8,
   parameter int SP_MAN_W = 23,
   parameter int DP_EXP_W = 11,
   parameter int DP_MAN_W = 52,
   localparam int SP_W = 1 + SP_EXP_W + SP_MAN_W,
   localparam int DP_W = 1 + DP_EXP_W + DP_MAN_W
) (
   input  logic [DP_W-1:0] dp,
   output logic [SP_W-1:0] sp
);
   localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
   localparam int DP_BIAS   = (1 << (DP_EXP_W - 1)) - 1;
   localparam int BIAS_DIFF = DP_BIAS - SP_BIAS;
   localparam int SP_EMAX   = (1 << SP_EXP_W) - 2;
   localparam int TOP_EXP   = BIAS_DIFF + SP_EMAX;
   localparam int PAD       = DP_MAN_W - SP_MAN_W;

   if (DP_MAN_W <= SP_MAN_W || DP_EXP_W <= SP_EXP_W) begin : g_bad_fmt
      $error("bfl_narrow: source format must be wider in both fields");
   end

   logic                d_sign;
   logic [DP_EXP_W-1:0] d_exp;
   logic [DP_MAN_W-1:0] d_frac;
   logic [SP_MAN_W-1:0] top_frac;
   logic [DP_EXP_W-1:0] rebias;

   assign d_sign   = dp[DP_W-1];
   assign d_exp    = dp[DP_W-2:DP_MAN_W];
   assign d_frac   = dp[DP_MAN_W-1:0];
   assign top_frac = d_frac[DP_MAN_W-1:PAD];
   assign rebias   = d_exp - DP_EXP_W'(BIAS_DIFF);

   always_comb begin
      if (&d_exp) begin
         if (d_frac != '0 && top_frac == '0) begin
            sp = {d_sign, {SP_EXP_W{1'b1}}, 1'b1, {(SP_MAN_W - 1){1'b0}}};
         end else begin
            sp = {d_sign, {SP_EXP_W{1'b1}}, top_frac};
         end
      end else if (d_exp > DP_EXP_W'(TOP_EXP)) begin
         sp = {d_sign, {SP_EXP_W{1'b1}}, {SP_MAN_W{1'b0}}};
      end else if (d_exp <= DP_EXP_W'(BIAS_DIFF)) begin
         sp = {d_sign, {(SP_W - 1){1'b0}}};
      end else begin
         sp = {d_sign, rebias[SP_EXP_W-1:0], top_frac};
      end
   end
endmodule

// File: rtl/bf16_fpreg_loader.sv
module bf16_fpreg_loader #(
   parameter int IMM_W    = 16,
   parameter int SP_EXP_W = 8,
   parameter int SP_MAN_W = 23,
   parameter int DP_EXP_W = 11,
   parameter int DP_MAN_W = 52,
   parameter bit NORM_SUB = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic        in_op,
   input  logic [15:0] in_imm,
   input  logic [63:0] in_reg,
   output logic        out_valid,
   output logic [63:0] out_value
);
   import bfl_pkg::*;

   localparam int SP_W = 1 + SP_EXP_W + SP_MAN_W;
   localparam int DP_W = 1 + DP_EXP_W + DP_MAN_W;
   localparam int PAD  = DP_MAN_W - SP_MAN_W;

   if (IMM_W != 16 || DP_W != 64) begin : g_bad_ports
      $error("bf16_fpreg_loader: port widths fix IMM_W=16 and a 64-bit target");
   end
   if (IMM_W >= SP_W) begin : g_bad_imm
      $error("bf16_fpreg_loader: immediate must be narrower than the single word");
   end

   bfl_op_e         op;
   logic [SP_W-1:0] narrowed;
   logic [SP_W-1:0] sp_word;
   logic [DP_W-1:0] widened;
   logic [IMM_W-1:0] unused_low;

   assign op         = bfl_op_e'(in_op);
   assign unused_low = narrowed[IMM_W-1:0];

   bfl_narrow #(
      .SP_EXP_W(SP_EXP_W), .SP_MAN_W(SP_MAN_W),
      .DP_EXP_W(DP_EXP_W), .DP_MAN_W(DP_MAN_W)
   ) u_narrow (
      .dp(in_reg),
      .sp(narrowed)
   );

   always_comb begin
      if (op == OP_PATCH) sp_word = {narrowed[SP_W-1:IMM_W], in_imm};
      else                sp_word = {in_imm, {(SP_W - IMM_W){1'b0}}};
   end

   bfl_widen #(
      .SP_EXP_W(SP_EXP_W), .SP_MAN_W(SP_MAN_W),
      .DP_EXP_W(DP_EXP_W), .DP_MAN_W(DP_MAN_W),
      .NORM_SUB(NORM_SUB)
   ) u_widen (
      .sp(sp_word),
      .dp(widened)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_value <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_value <= widened;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R8
   AST_VALUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_value)); // R8
   AST_LOAD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 1'b0) |=> out_value[63] == $past(in_imm[15])); // R1
   AST_LOAD_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 1'b0 && (&in_imm[14:7])) |=> (&out_value[62:52])); // R3
   AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_value[PAD-1:0] == '0); // R2
endmodule

// File: tb/bf16_fpreg_loader_test.sv
`timescale 1ns/1ps
module bf16_fpreg_loader_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_op = 1'b0;
   logic [15:0] in_imm = '0;
   logic [63:0] in_reg = '0;
   logic        out_valid;
   logic [63:0] out_value;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   bf16_fpreg_loader uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_imm(in_imm), .in_reg(in_reg), .out_valid(out_valid), .out_value(out_value)
   );

   function automatic logic [63:0] ref_widen(input logic [31:0] x);
      logic        s;
      int          e;
      logic [23:0] m;
      int          de;
      s = x[31];
      e = int'(x[30:23]);
      m = {1'b0, x[22:0]};
      if (e == 255) return {s, 11'h7FF, x[22:0], 29'b0};
      if (e == 0 && m == 0) return {s, 63'b0};
      if (e == 0) begin
         de = 897;
         while (m[23] == 1'b0) begin
            m  = m << 1;
            de = de - 1;
         end
         return {s, 11'(de), m[22:0], 29'b0};
      end
      return {s, 11'(e + 896), x[22:0], 29'b0};
   endfunction

   function automatic logic [31:0] ref_narrow(input logic [63:0] x);
      int          e;
      logic [22:0] m;
      e = int'(x[62:52]);
      m = x[51:29];
      if (e == 2047) begin
         if (x[51:0] != 0 && m == 0) m = 23'h400000;
         return {x[63], 8'hFF, m};
      end
      if (e - 896 >= 255) return {x[63], 8'hFF, 23'h0};
      if (e - 896 <= 0)   return {x[63], 31'h0};
      return {x[63], 8'(e - 896), m};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic op, input logic [15:0] imm, input logic [63:0] rv,
                         output logic [63:0] res, output logic vld);
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = op;
      in_imm   = imm;
      in_reg   = rv;
      @(posedge clk);
      #1;
      res = out_value;
      vld = out_valid;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic do_load(input string req, input logic [15:0] imm, input logic [63:0] lit);
      logic [63:0] r;
      logic        v;
      run_op(1'b0, imm, 64'h0, r, v);
      check({req, " valid"}, 64'(v), 64'd1);
      check(req, r, lit);
      check({req, " model"}, r, ref_widen({imm, 16'h0}));
   endtask

   task automatic do_patch(input string req, input logic [63:0] rv, input logic [15:0] imm,
                           input logic [63:0] lit, input bit use_lit);
      logic [63:0] r;
      logic        v;
      logic [31:0] n;
      run_op(1'b1, imm, rv, r, v);
      n = ref_narrow(rv);
      check({req, " valid"}, 64'(v), 64'd1);
      check({req, " model"}, r, ref_widen({n[31:16], imm}));
      if (use_lit) check(req, r, lit);
   endtask

   task automatic t_reset;
      #1;
      check("R9 out_valid in reset", 64'(out_valid), 64'd0);
      check("R9 out_value in reset", out_value, 64'd0);
   endtask

   task automatic t_load_signed_zero;
      do_load("R1 +0", 16'h0000, 64'h0000_0000_0000_0000);
      do_load("R1 -0", 16'h8000, 64'h8000_0000_0000_0000);
   endtask

   task automatic t_load_normals;
      do_load("R2 +1.0", 16'h3F80, 64'h3FF0_0000_0000_0000);
      do_load("R2 -1.5", 16'hBFC0, 64'hBFF8_0000_0000_0000);
      do_load("R2 1.9921875", 16'h3FFF, 64'h3FFF_E000_0000_0000);
      do_load("R2 large", 16'h7F7F, ref_widen(32'h7F7F_0000));
   endtask

   task automatic t_load_specials;
      do_load("R3 +inf", 16'h7F80, 64'h7FF0_0000_0000_0000);
      do_load("R3 -inf", 16'hFF80, 64'hFFF0_0000_0000_0000);
      do_load("R3 qnan", 16'h7FC0, 64'h7FF8_0000_0000_0000);
   endtask

   task automatic t_subnormals;
      do_load("R4 0x0001", 16'h0001, 64'h37A0_0000_0000_0000);
      do_load("R4 0x0040", 16'h0040, 64'h3800_0000_0000_0000);
      do_load("R4 0x8055", 16'h8055, ref_widen(32'h8055_0000));
      do_patch("R4 patch tiny", 64'h0, 16'h0001, 64'h36A0_0000_0000_0000, 1'b1);
   endtask

   task automatic t_patch_chain;
      logic [63:0] r;
      logic        v;
      run_op(1'b0, 16'h3F80, 64'h0, r, v);
      check("R5 chain first", r, 64'h3FF0_0000_0000_0000);
      run_op(1'b1, 16'h8000, r, r, v);
      check("R5 chain second", r, 64'h3FF0_1000_0000_0000);
      do_patch("R5 -1.5 patch", 64'hBFF8_0000_0000_0000, 16'h1234, 64'h0, 1'b0);
   endtask

   task automatic t_truncate;
      do_patch("R6 drop low bits", 64'h3FF0_0000_1FFF_FFFF, 16'h0000,
               64'h3FF0_0000_0000_0000, 1'b1);
      do_patch("R6 no round up", 64'h4000_0000_3FFF_FFFF, 16'h0000,
               64'h4000_0000_0000_0000, 1'b1);
   endtask

   task automatic t_range;
      do_patch("R7 overflow to inf", 64'h7FE0_0000_0000_0000, 16'h0000,
               64'h7FF0_0000_0000_0000, 1'b1);
      do_patch("R7 underflow +0", 64'h0010_0000_0000_0000, 16'h0000,
               64'h0000_0000_0000_0000, 1'b1);
      do_patch("R7 underflow -0", 64'h8010_0000_0000_0000, 16'h0000,
               64'h8000_0000_0000_0000, 1'b1);
      do_patch("R7 nan low payload", 64'h7FF0_0000_0000_0001, 16'h0000,
               64'h7FF8_0000_0000_0000, 1'b1);
      do_patch("R7 edge exp 1150", 64'h47E0_0000_0000_0000, 16'h0000,
               64'h47E0_0000_0000_0000, 1'b1);
   endtask

   task automatic t_timing;
      logic [63:0] held;
      @(negedge clk);
      in_valid = 1'b1; in_op = 1'b0; in_imm = 16'h3F80; in_reg = '0;
      @(negedge clk);
      check("R8 first of pair valid", 64'(out_valid), 64'd1);
      check("R8 first of pair value", out_value, 64'h3FF0_0000_0000_0000);
      in_imm = 16'hBFC0;
      @(negedge clk);
      in_valid = 1'b0;
      in_imm   = 16'h7F80;
      check("R8 second of pair value", out_value, 64'hBFF8_0000_0000_0000);
      held = out_value;
      @(negedge clk);
      check("R8 valid drops", 64'(out_valid), 64'd0);
      repeat (3) @(negedge clk);
      check("R8 value held while idle", out_value, held);
      check("R8 valid stays low", 64'(out_valid), 64'd0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_load_signed_zero();
      t_load_normals();
      t_load_specials();
      t_subnormals();
      t_patch_chain();
      t_truncate();
      t_range();
      t_timing();
      finish_run();
   end
endmodule